// File: doc/BRIEF.md
# Dual-Style Parallel Host Port

This block is the slave end of a parallel host bus. One decoder serves two host bus styles. In the first style the host uses separate active-low read and write strobes. In the second style the host uses an active-high enable together with a read/not-write level. The bus is 16 or 8 bits wide. Style and width are set by three static mode pins.

Each access is sorted by the A0 line into one of four kinds:
- command write
- parameter or pixel write
- memory read
- status read

Write values pass through a single holding register and are handed to the core one cycle after capture. The core sees them on a one-cycle write strobe that carries a command flag.

A memory read returns whatever the holding register contains. It then asks the core for the next word and refills the register from the reply, so memory reads are pipelined by one access. The first memory read after a write returns that write's value, which the host treats as a dummy word. The data bus is brought out as separate in, out and per-byte-lane enable signals, so that pad cells can form the bidirectional pins.

Host strobes and chip select pass through two-flop synchronizers, and accesses are recognised on strobe edges. The host must hold A0 and the write data stable for at least three clock cycles after it releases the write strobe.

Top module: `hpi_top`

## Requirements
- R1: The mode pins select the bus: 3'b111 is strobe style 16-bit, 3'b110 is strobe style 8-bit, 3'b100 is enable style 16-bit, 3'b011 is enable style 8-bit. Any other code makes the block ignore every access: no write strobe, no read request, and data_oe stays 0.
- R2: A write with a0 low is a command. Its byte appears on wr_data[7:0] with wr_cmd = 1.
- R3: A write with a0 high is a parameter or pixel word. It appears on wr_data with wr_cmd = 0.
- R4: In strobe style, write data is captured when wr_rw rises. If the release happens between rising edge k and edge k+1, wr_stb is high for exactly the one cycle after rising edge k+4.
- R5: In enable style, rd_e high enables an access and wr_rw high means read. A write is captured when rd_e falls, with the same edge timing as R4.
- R6: While cs_n is high, data_oe is 0 and strobe activity causes no write or read.
- R7: In 8-bit modes, data_oe[1] is always 0, data_in[15:8] is ignored, and wr_data[15:8] is 0.
- R8: A memory read (a0 high) drives the holding register's value on data_out. rd_req is high for one cycle, the cycle after rising edge k+3 when the read begins between edges k and k+1. The holding register takes rd_data at the edge that ends that cycle.
- R9: After reset the holding register is 0. A write loads it with the written value, so the next memory read returns that value.
- R10: A status read (a0 low) drives {8'h00, status_in} on data_out, raises no rd_req and leaves the holding register unchanged.
- R11: data_oe follows the raw read condition while cs_n is low: rd_e low in strobe style, or rd_e and wr_rw both high in enable style. Both lanes are enabled in 16-bit modes.
- R12: During and right after reset, wr_stb, rd_req, data_out and data_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Static bus style and width select |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Access kind: 0 command/status, 1 data |
| rd_e | input | 1 | Read strobe (active low) or enable (active high) |
| wr_rw | input | 1 | Write strobe (active low) or read/not-write |
| data_in | input | 16 | Host data from pads |
| data_out | output | 16 | Data toward pads during reads |
| data_oe | output | 2 | Per-lane pad output enable |
| status_in | input | 8 | Status byte from core |
| wr_stb | output | 1 | One-cycle write to core |
| wr_cmd | output | 1 | Write is a command |
| wr_data | output | 16 | Write value to core |
| rd_req | output | 1 | One-cycle memory word request |
| rd_data | input | 16 | Memory word, valid while rd_req is high |

## Verification
The hardest case is the pipelined read. Its result depends on every write and read that came before it, so the bench keeps its own model of the holding register and mixes writes, memory reads and status reads in one sequence. Specific orderings reach each corner: a dummy read right after a write, a read right after another read, and a status read placed between two memory reads. The bench supplies memory words from a counter and compares wr_stb and rd_req against scheduled cycles on every clock, which pins down the synchronizer latency in both bus styles.

// File: rtl/hpi_pkg.sv
// Package: shared configuration type and mode decode for the host port.
// Assumes mode_sel is static while accesses are in progress.
package hpi_pkg;

    typedef struct packed {
        logic valid;   // a recognised code
        logic is68;    // enable + read/not-write style
        logic wide;    // 16-bit bus
    } bus_cfg_t;

    // Maps the three mode pins onto a bus configuration.
    function automatic bus_cfg_t decode_cfg(input logic [2:0] m);
        bus_cfg_t c;
        c = '0;
        case (m)
            3'b111:  c = '{valid: 1'b1, is68: 1'b0, wide: 1'b1};
            3'b110:  c = '{valid: 1'b1, is68: 1'b0, wide: 1'b0};
            3'b100:  c = '{valid: 1'b1, is68: 1'b1, wide: 1'b1};
            3'b011:  c = '{valid: 1'b1, is68: 1'b1, wide: 1'b0};
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hpi_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous levels.
// Assumes each bit is an independent level; no bus coherency is implied.
module hpi_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hpi_detect.sv
// Module: turns synchronized strobes into write-end and read-start pulses.
// Assumes inputs are already synchronized; output pulses are combinational
// from the last synchronizer stage and one history register.
module hpi_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic is68,
    input  logic cs_s,
    input  logic rde_s,
    input  logic wrrw_s,
    output logic wr_done,
    output logic rd_begin
);
    logic rd_act, wr_act, rd_g, wr_g;
    logic rd_prev, wr_prev;

    // Interpret the two strobe pins according to bus style.
    always_comb begin
        if (is68) begin
            rd_act = rde_s & wrrw_s;
            wr_act = rde_s & ~wrrw_s;
        end else begin
            rd_act = ~rde_s;
            wr_act = ~wrrw_s;
        end
        rd_g = valid & ~cs_s & rd_act;
        wr_g = valid & ~cs_s & wr_act;
    end

    // Remember last cycle's gated activity for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_g;
            wr_prev <= wr_g;
        end
    end

    assign rd_begin = rd_g & ~rd_prev;
    assign wr_done  = valid & ~cs_s & wr_prev & ~wr_act;
endmodule

// File: rtl/hpi_holder.sv
// Module: holding register shared by writes and pipelined memory reads.
// Assumes a0 and data_in are stable when wr_done/rd_begin pulse and that
// rd_data is valid during the cycle rd_req is high.
module hpi_holder #(
    parameter int DW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          wr_done,
    input  logic          rd_begin,
    input  logic          a0,
    input  logic [DW-1:0] data_in,
    input  logic [LW-1:0] status_in,
    input  logic [DW-1:0] rd_data,
    output logic          wr_stb,
    output logic          wr_cmd,
    output logic [DW-1:0] wr_data,
    output logic          rd_req,
    output logic [DW-1:0] rd_out
);
    logic [DW-1:0] hold_q;
    logic          commit_q;
    logic          cmd_q;
    logic [DW-1:0] din_m;

    // Mask the upper lanes in narrow modes.
    assign din_m = wide ? data_in : {{(DW-LW){1'b0}}, data_in[LW-1:0]};

    // Holding register: refill from memory, else capture a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (rd_req) begin
            hold_q <= rd_data;
        end else if (wr_done) begin
            hold_q <= din_m;
        end
    end

    // Pending commit flag and its command qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            cmd_q    <= 1'b0;
        end else begin
            commit_q <= wr_done;
            if (wr_done) cmd_q <= ~a0;
        end
    end

    // Commit the parked write to the core one cycle after capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_cmd  <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_stb <= commit_q;
            if (commit_q) begin
                wr_cmd  <= cmd_q;
                wr_data <= hold_q;
            end
        end
    end

    // Read launch: present held word or status and request the next word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req <= 1'b0;
            rd_out <= '0;
        end else begin
            rd_req <= rd_begin & a0;
            if (rd_begin) begin
                rd_out <= a0 ? hold_q : {{(DW-LW){1'b0}}, status_in};
            end
        end
    end
endmodule

// File: rtl/hpi_top.sv
// Module: dual-style parallel host port top level.
// Assumes mode_sel is static, the host holds a0/data_in for three clocks
// after a write strobe ends, and pads combine data_out/data_oe/data_in.
module hpi_top
    import hpi_pkg::*;
#(
    parameter int DW          = 16,
    parameter int LW          = 8,
    parameter int SYNC_STAGES = 2,
    localparam int LANES      = DW / LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    input  logic             cs_n,
    input  logic             a0,
    input  logic             rd_e,
    input  logic             wr_rw,
    input  logic [DW-1:0]    data_in,
    output logic [DW-1:0]    data_out,
    output logic [LANES-1:0] data_oe,
    input  logic [LW-1:0]    status_in,
    output logic             wr_stb,
    output logic             wr_cmd,
    output logic [DW-1:0]    wr_data,
    output logic             rd_req,
    input  logic [DW-1:0]    rd_data
);
    bus_cfg_t   cfg;
    logic [2:0] sync_q;
    logic       wr_done, rd_begin, rd_raw, oe_base;

    assign cfg = decode_cfg(mode_sel);

    hpi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, rd_e, wr_rw}),
        .q     (sync_q)
    );

    hpi_detect u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (cfg.valid),
        .is68     (cfg.is68),
        .cs_s     (sync_q[2]),
        .rde_s    (sync_q[1]),
        .wrrw_s   (sync_q[0]),
        .wr_done  (wr_done),
        .rd_begin (rd_begin)
    );

    hpi_holder #(.DW(DW), .LW(LW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide      (cfg.wide),
        .wr_done   (wr_done),
        .rd_begin  (rd_begin),
        .a0        (a0),
        .data_in   (data_in),
        .status_in (status_in),
        .rd_data   (rd_data),
        .wr_stb    (wr_stb),
        .wr_cmd    (wr_cmd),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .rd_out    (data_out)
    );

    // Raw read condition drives the pads without synchronizer delay.
    always_comb begin
        rd_raw  = cfg.is68 ? (rd_e & wr_rw) : ~rd_e;
        oe_base = cfg.valid & ~cs_n & rd_raw;
    end

    // Lane 0 always follows the read; upper lanes only in wide modes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign data_oe[g] = oe_base;
        end else begin : g_up
            assign data_oe[g] = oe_base & cfg.wide;
        end
    end
endmodule

// File: rtl/hpi_checker.sv
// Module: temporal checks on the host port, bound to hpi_top.
// Assumes mode_sel is static while checked.
module hpi_checker
    import hpi_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  mode_sel,
    input logic        cs_n,
    input logic [1:0]  data_oe,
    input logic        wr_stb,
    input logic [15:0] wr_data,
    input logic        rd_req
);
    bus_cfg_t c;
    assign c = decode_cfg(mode_sel);

    p_hiz_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (data_oe == 2'b00));

    p_upper_lane_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !c.wide |-> !data_oe[1]);

    p_narrow_wdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !c.wide) |-> (wr_data[15:8] == 8'h00));

    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    p_bad_mode_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !c.valid |-> (data_oe == 2'b00));
endmodule

bind hpi_top hpi_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .cs_n     (cs_n),
    .data_oe  (data_oe),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .rd_req   (rd_req)
);

// File: tb/tb_hpi_top.sv
module tb_hpi_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  mode_sel = 3'b111;
    logic        cs_n = 1, a0 = 0, rd_e = 1, wr_rw = 1;
    logic [15:0] data_in = 0, rd_data = 0;
    logic [7:0]  status_in = 8'h5C;
    logic [15:0] data_out, wr_data;
    logic [1:0]  data_oe;
    logic        wr_stb, wr_cmd, rd_req;

    always #2 clk = ~clk;   // 250 MHz

    hpi_top dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .a0(a0),
        .rd_e(rd_e), .wr_rw(wr_rw), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .status_in(status_in), .wr_stb(wr_stb),
        .wr_cmd(wr_cmd), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0, mon_on = 0;
    int wq_cyc[$], wq_dat[$], wq_cmd[$], rq_cyc[$];
    int hold_m = 0, mem_pred = 16'hA000, mem_next = 16'hA000;
    bit is68 = 0, wide = 1, active = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) cyc++;

    // Memory model: answers each request in the same cycle.
    always @(negedge clk) if (rd_req) begin
        rd_data = mem_next[15:0];
        mem_next++;
    end

    // Every-clock comparison of the core-side strobes against the schedule.
    always @(negedge clk) if (mon_on) begin
        if (wq_cyc.size() > 0 && wq_cyc[0] == cyc) begin
            chk(wr_stb == 1, "R4 wr_stb", wr_stb, 1);
            chk(wr_data == wq_dat[0][15:0], "R3 wr_data", wr_data, wq_dat[0]);
            chk(wr_cmd == wq_cmd[0][0], "R2 wr_cmd", wr_cmd, wq_cmd[0]);
            void'(wq_cyc.pop_front()); void'(wq_dat.pop_front()); void'(wq_cmd.pop_front());
        end else begin
            chk(wr_stb == 0, "R4 wr_stb idle", wr_stb, 0);
        end
        if (rq_cyc.size() > 0 && rq_cyc[0] == cyc) begin
            chk(rd_req == 1, "R8 rd_req", rd_req, 1);
            void'(rq_cyc.pop_front());
        end else begin
            chk(rd_req == 0, "R8 rd_req idle", rd_req, 0);
        end
    end

    task automatic set_mode(input logic [2:0] m, input bit s68, input bit w, input bit act);
        @(posedge clk); #1;
        mode_sel = m; is68 = s68; wide = w; active = act;
        cs_n = 1; rd_e = s68 ? 1'b0 : 1'b1; wr_rw = 1;
        repeat (4) @(posedge clk);
    endtask

    task automatic host_write(input bit a, input logic [15:0] d);
        int k, dm;
        @(posedge clk); #1;
        a0 = a; data_in = d; cs_n = 0;
        if (is68) begin wr_rw = 0; rd_e = 1; end else wr_rw = 0;
        repeat (3) @(posedge clk); #1;
        if (is68) rd_e = 0; else wr_rw = 1;
        k = cyc;
        dm = wide ? d : {8'h00, d[7:0]};
        if (active) begin
            wq_cyc.push_back(k + 4); wq_dat.push_back(dm); wq_cmd.push_back(a ? 0 : 1);
            hold_m = dm;
        end
        repeat (5) @(posedge clk); #1;
        cs_n = 1; wr_rw = 1; data_in = 0;
        repeat (2) @(posedge clk);
    endtask

    task automatic host_read(input bit a, input string req);
        int k, exp;
        @(posedge clk); #1;
        a0 = a; cs_n = 0;
        if (is68) begin wr_rw = 1; rd_e = 1; end else rd_e = 0;
        k = cyc;
        exp = 0;
        if (active) begin
            if (a) begin
                exp = hold_m; hold_m = mem_pred; mem_pred++;
                rq_cyc.push_back(k + 3);
            end else exp = {8'h00, status_in};
        end
        repeat (5) @(negedge clk);
        if (!active) begin
            chk(data_oe == 2'b00, "R1 oe off in bad mode", data_oe, 0);
        end else begin
            chk(data_oe == (wide ? 2'b11 : 2'b01), "R11 oe", data_oe, wide ? 3 : 1);
            if (wide) chk(data_out == exp[15:0], req, data_out, exp);
            else      chk(data_out[7:0] == exp[7:0], req, data_out[7:0], exp[7:0]);
        end
        @(posedge clk); #1;
        if (is68) rd_e = 0; else rd_e = 1;
        cs_n = 1;
        @(negedge clk);
        chk(data_oe == 2'b00, "R11 oe released", data_oe, 0);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(wr_stb == 0 && rd_req == 0, "R12 reset strobes", {wr_stb, rd_req}, 0);
        chk(data_out == 0 && data_oe == 0, "R12 reset bus", data_out, 0);
        @(posedge clk); #1 rst_n = 1;
        mon_on = 1;
        @(negedge clk);
        chk(data_out == 0, "R12 after reset", data_out, 0);

        // Strobe style, 16-bit.
        host_write(0, 16'h002A);            // R2 command
        host_write(1, 16'hBEEF);            // R3 data
        host_read(1, "R9 dummy read");      // returns BEEF
        host_read(1, "R8 pipelined read");  // returns A000
        host_read(0, "R10 status read");
        host_read(1, "R10 holder kept");    // returns A001

        // R6: strobes while deselected.
        @(posedge clk); #1 cs_n = 1; rd_e = 0; wr_rw = 0; a0 = 1; data_in = 16'h1111;
        repeat (4) @(negedge clk);
        chk(data_oe == 2'b00, "R6 oe while deselected", data_oe, 0);
        @(posedge clk); #1 rd_e = 1; wr_rw = 1;
        repeat (8) @(posedge clk);
        host_read(1, "R6 holder untouched"); // returns A002

        // Strobe style, 8-bit.
        set_mode(3'b110, 0, 0, 1);
        host_write(1, 16'h1234);            // R7 masked to 0034
        host_read(1, "R7 narrow dummy read");

        // Enable style, 16-bit.
        set_mode(3'b100, 1, 1, 1);
        host_write(0, 16'h0077);            // R5 command
        host_write(1, 16'hCAFE);            // R5 data
        host_read(1, "R5 enable-style dummy read");
        host_read(1, "R5 enable-style read");

        // Enable style, 8-bit.
        set_mode(3'b011, 1, 0, 1);
        host_write(1, 16'hABCD);
        host_read(1, "R7 enable-style narrow read");
        host_read(0, "R10 narrow status");

        // Unrecognised code.
        set_mode(3'b000, 0, 1, 0);
        host_write(1, 16'h5555);
        host_read(1, "R1 bad mode read");

        repeat (10) @(posedge clk);
        chk(wq_cyc.size() == 0 && rq_cyc.size() == 0, "R4 all scheduled events seen",
            wq_cyc.size() + rq_cyc.size(), 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    always @(posedge clk) if (cyc > 20000 && !done) begin
        done = 1;
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule